// File: doc/BRIEF.md
# Test Clock Generator with Divided and Adaptive Modes

This block produces the test clock (TCK) for a JTAG master from a fixed 64 MHz reference. It has two ways of pacing the clock. In divided mode, TCK runs at the reference frequency divided by a programmable even divisor. In adaptive mode, each new TCK edge waits until the target returns the previous edge on its returned-clock input (RCLK). A bounded wait stops a silent target from stalling the engine forever: when the wait runs out, a sticky error flag is raised and the clock carries on.

The shift engine asks for edges by holding `tick_req` high. The generator answers with a one-cycle `edge_en` pulse in every cycle where TCK changes, so the engine can move its data in step with the clock. The divisor and the mode are taken in only in cycles where the shift engine reports that it is idle. A clock change therefore never lands in the middle of a scan. The error flag has its own clear input, so software can discard the false timeouts that come with a test-reset.

Top module: `tckgen_core`

## Requirements
- R1: During reset and in the first cycle after it, `tck` is 0, `edge_en` is 0 and `timeout_err` is 0.
- R2: In divided mode with `tick_req` held high, the first TCK toggle comes H reference cycles after the request is first sampled. Each later toggle comes H cycles after the one before, so one TCK period lasts 2H = the effective divisor.
- R3: The divisor field is 13 bits wide and bit 0 is ignored. H equals `div_value[12:1]`, except that a value of 0 or 1 acts as 2 (H = 1). The largest setting, 8190, also covers a written 8191.
- R4: `edge_en` is high in exactly those cycles in which `tck` differs from its value in the previous cycle.
- R5: While `tick_req` is low, `tck` holds its level and `edge_en` stays low.
- R6: `div_value` and `adaptive_sel` are taken in only at clock edges where `engine_idle` is high. Changes made while it is low have no effect on the running clock.
- R7: In adaptive mode (`adaptive_sel` = 1), a request that finds no edge pending toggles TCK at the first sampled edge. The next toggle waits until the two-flop-synchronised RCLK equals TCK. An echo applied D cycles after a toggle becomes visible gives an edge spacing of 4 + D cycles.
- R8: In adaptive mode, if the echo has not matched within TMO_CYCLES cycles after a toggle, `timeout_err` is set and the next edge is allowed. With the request held, this gives an edge spacing of TMO_CYCLES + 1.
- R9: `timeout_err` stays set until `err_clr` is sampled high (a timeout in the same cycle wins). It is never set in divided mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 64 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_value | input | 13 | Requested divisor (bit 0 ignored) |
| adaptive_sel | input | 1 | 1 selects returned-clock pacing, 0 selects the divider |
| rclk_in | input | 1 | Returned clock from the target, asynchronous |
| tick_req | input | 1 | Shift engine asks for TCK edges while high |
| engine_idle | input | 1 | Shift engine idle; configuration is loaded while high |
| err_clr | input | 1 | Clears the sticky timeout flag |
| tck | output | 1 | Generated test clock |
| edge_en | output | 1 | One-cycle pulse in every cycle where `tck` changed |
| timeout_err | output | 1 | Sticky returned-clock timeout flag |

## Verification
The divided mode is swept over small divisors from 0 to 33, plus 100, 8190 and 8191. This separates the clamp for 0/1, the dropped bit 0 for odd values and an off-by-one in the half-period count, and the largest values show that no bit is lost at the top. The adaptive mode is driven by a bench loopback that echoes each edge after 0, 3 or 7 cycles, so the 4 + D spacing pins down the synchroniser depth and the compare latency. A silent target exercises the timeout, the sticky flag and its clear. Configuration writes with `engine_idle` low, in both mode and divisor, must leave the running clock unchanged.

// File: rtl/tckgen_pkg.sv
// Package: shared types for the test clock generator.
// Assumes: nothing; holds only the pacing-mode encoding.
package tckgen_pkg;

    // Pacing mode of the generator
    typedef enum logic {
        CLK_DIVIDED  = 1'b0,
        CLK_ADAPTIVE = 1'b1
    } clk_mode_e;

endpackage

// File: rtl/tckgen_cfg.sv
// Module: tckgen_cfg
// Holds the active divisor (as a half period) and the pacing mode.
// Both are loaded only while the shift engine reports idle.
// Assumes: DIV_W >= 2; bit 0 of the divisor carries no meaning.
module tckgen_cfg
    import tckgen_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             mode_in,
    output logic [DIV_W-2:0] half_o,
    output clk_mode_e        mode_o
);
    localparam int HALF_W = DIV_W - 1;

    logic [HALF_W-1:0] half_next;

    // Turn the written divisor into a half period of at least one cycle
    always_comb begin
        half_next = div_in[DIV_W-1:1];
        if (half_next == '0) begin
            half_next = HALF_W'(1);
        end
    end

    // Load the configuration only while the engine is idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_o <= HALF_W'(1);
            mode_o <= CLK_DIVIDED;
        end else if (load) begin
            half_o <= half_next;
            mode_o <= clk_mode_e'(mode_in);
        end
    end
endmodule

// File: rtl/tckgen_halfcnt.sv
// Module: tckgen_halfcnt
// Counts reference cycles while edges are requested and fires once
// every half period. The count restarts whenever the request drops.
// Assumes: half >= 1 (guaranteed by tckgen_cfg).
module tckgen_halfcnt #(
    parameter int HALF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              req,
    input  logic [HALF_W-1:0] half,
    output logic              fire_o
);
    logic [HALF_W-1:0] cnt;
    logic              at_end;

    // End of half period; the >= keeps a shrunk half period safe
    always_comb begin
        at_end = (cnt >= (half - HALF_W'(1)));
        fire_o = en && req && at_end;
    end

    // Half-period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || !req || at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/tckgen_sync.sv
// Module: tckgen_sync
// Flop chain that brings an asynchronous level into the clock domain.
// Assumes: STAGES >= 2; the output resets to 0.
module tckgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // Later stages follow the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tckgen_echo.sv
// Module: tckgen_echo
// Returned-clock pacing: it allows an edge, then waits until the
// synchronised echo equals the clock. It gives up after TMO_CYCLES
// and reports a timeout.
// Assumes: tck is the registered clock that toggles in the cycle after fire_o.
module tckgen_echo #(
    parameter int TMO_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic tck,
    input  logic echo_s,
    output logic fire_o,
    output logic timeout_o
);
    localparam int TCNT_W = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [TCNT_W-1:0] TLAST = TCNT_W'(TMO_CYCLES - 1);

    logic              waiting;
    logic [TCNT_W-1:0] tcnt;
    logic              matched;

    // Decide whether an edge may go out now, or the wait has expired
    always_comb begin
        matched   = (echo_s == tck);
        fire_o    = en && req && !waiting;
        timeout_o = en && waiting && !matched && (tcnt == TLAST);
    end

    // Track the outstanding echo and its timeout count
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            waiting <= 1'b0;
            tcnt    <= '0;
        end else if (fire_o) begin
            waiting <= 1'b1;
            tcnt    <= '0;
        end else if (waiting) begin
            if (matched || timeout_o) begin
                waiting <= 1'b0;
            end else begin
                tcnt <= tcnt + TCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/tckgen_core.sv
// Module: tckgen_core (top)
// Test clock generator. In divided mode TCK is paced by a half-period
// counter; in adaptive mode each edge waits for the returned clock.
// A sticky flag reports echo timeouts.
// Assumes: clk is the 64 MHz reference; rclk_in is asynchronous.
module tckgen_core
    import tckgen_pkg::*;
#(
    parameter int DIV_W       = 13,
    parameter int TMO_CYCLES  = 65536,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_value,
    input  logic             adaptive_sel,
    input  logic             rclk_in,
    input  logic             tick_req,
    input  logic             engine_idle,
    input  logic             err_clr,
    output logic             tck,
    output logic             edge_en,
    output logic             timeout_err
);
    localparam int HALF_W = DIV_W - 1;

    logic [HALF_W-1:0] cfg_half;
    clk_mode_e         cfg_mode;
    logic              adaptive_on;
    logic              rclk_s;
    logic              fire_div;
    logic              fire_echo;
    logic              echo_tmo;
    logic              step;
    logic              tck_q;
    logic              edge_q;
    logic              err_q;

    tckgen_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (engine_idle),
        .div_in (div_value),
        .mode_in(adaptive_sel),
        .half_o (cfg_half),
        .mode_o (cfg_mode)
    );

    assign adaptive_on = (cfg_mode == CLK_ADAPTIVE);

    tckgen_halfcnt #(.HALF_W(HALF_W)) u_halfcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (!adaptive_on),
        .req   (tick_req),
        .half  (cfg_half),
        .fire_o(fire_div)
    );

    tckgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rclk_in),
        .q    (rclk_s)
    );

    tckgen_echo #(.TMO_CYCLES(TMO_CYCLES)) u_echo (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (adaptive_on),
        .req      (tick_req),
        .tck      (tck_q),
        .echo_s   (rclk_s),
        .fire_o   (fire_echo),
        .timeout_o(echo_tmo)
    );

    // Either pacing source may release the next edge
    assign step = fire_div || fire_echo;

    // Clock output and the edge strobe for the shift engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            tck_q  <= tck_q ^ step;
            edge_q <= step;
        end
    end

    // Sticky timeout flag; a new timeout wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (echo_tmo) err_q <= 1'b1;
        else if (err_clr)  err_q <= 1'b0;
    end

    assign tck         = tck_q;
    assign edge_en     = edge_q;
    assign timeout_err = err_q;
endmodule

// File: rtl/tckgen_core_chk.sv
// Module: tckgen_core_chk
// Property checker bound to tckgen_core.
// Assumes: it sees the top ports and the active pacing mode.
module tckgen_core_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_req,
    input logic err_clr,
    input logic tck,
    input logic edge_en,
    input logic timeout_err,
    input logic mode_active
);
    // R1: outputs are quiet in the cycle after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!tck && !edge_en && !timeout_err));

    // R4: the strobe marks exactly the cycles where the clock moved
    a_r4_strobe_tracks_tck: assert property (@(posedge clk) disable iff (!rst_n)
        edge_en == (tck != $past(tck)));

    // R5: no edge without a request in the cycle before
    a_r5_edge_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        edge_en |-> $past(tick_req));

    // R7: in adaptive mode two edges never come back to back
    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_en && mode_active) |=> (!edge_en || !mode_active));

    // R8: a timeout is only ever raised in adaptive mode
    a_r8_err_only_adaptive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> $past(mode_active));

    // R9: the flag stays set until a clear is seen
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(timeout_err) && !$past(err_clr)) |-> timeout_err);
endmodule

bind tckgen_core tckgen_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_req   (tick_req),
    .err_clr    (err_clr),
    .tck        (tck),
    .edge_en    (edge_en),
    .timeout_err(timeout_err),
    .mode_active(adaptive_on)
);

// File: tb/tckgen_core_bench.sv
// Bench for tckgen_core: divisor sweep, adaptive loopback, timeout.
module tckgen_core_bench;
    localparam int DIV_W = 13;
    localparam int TMO   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_value = '0;
    logic             adaptive_sel = 1'b0;
    logic             rclk_in = 1'b0;
    logic             tick_req = 1'b0;
    logic             engine_idle = 1'b0;
    logic             err_clr = 1'b0;
    logic             tck, edge_en, timeout_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    tckgen_core #(.DIV_W(DIV_W), .TMO_CYCLES(TMO), .SYNC_STAGES(2)) u_tckgen_core (
        .clk(clk), .rst_n(rst_n), .div_value(div_value), .adaptive_sel(adaptive_sel),
        .rclk_in(rclk_in), .tick_req(tick_req), .engine_idle(engine_idle),
        .err_clr(err_clr), .tck(tck), .edge_en(edge_en), .timeout_err(timeout_err)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "WATCHDOG", "run did not finish", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int exp_half(input int d);
        int h = (d % 8192) / 2;
        return (h == 0) ? 1 : h;
    endfunction

    // Load configuration in one idle cycle
    task automatic load_cfg(input int d, input bit mode);
        @(negedge clk);
        div_value    = DIV_W'(d);
        adaptive_sel = mode;
        engine_idle  = 1'b1;
        @(negedge clk);
        engine_idle  = 1'b0;
    endtask

    // Hold the request and time n edges; optionally echo each edge back
    task automatic run_edges(input int n, input int first_exp, input int gap_exp,
                             input bit echo, input int echo_d, input string req);
        int   cyc = 0, last = 0, seen = 0, cd = -1, limit;
        bit   bad_en = 1'b0, bad_gap = 1'b0;
        int   bad_act = 0, bad_exp = 0;
        logic prev;
        limit = first_exp + n * gap_exp + 50;
        prev  = tck;
        tick_req = 1'b1;
        while (seen < n && cyc < limit) begin
            @(negedge clk);
            cyc++;
            if (edge_en !== (tck !== prev)) bad_en = 1'b1;
            if (tck !== prev) begin
                int e = (seen == 0) ? first_exp : last + gap_exp;
                if (cyc != e && !bad_gap) begin
                    bad_gap = 1'b1; bad_act = cyc; bad_exp = e;
                end
                last = cyc; seen++; prev = tck;
                if (echo) cd = echo_d;
            end
            if (echo) begin
                if (cd == 0) begin rclk_in = tck; cd = -1; end
                else if (cd > 0) cd--;
            end
        end
        tick_req = 1'b0;
        check(!bad_gap, req, "edge cycle", bad_act, bad_exp);
        check(seen == n, req, "edge count", seen, n);
        check(!bad_en, "R4", "strobe matches tck change", int'(bad_en), 0);
        if (echo) begin
            repeat (echo_d) @(negedge clk);
            rclk_in = tck;
            repeat (5) @(negedge clk);
        end else begin
            @(negedge clk);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(tck === 1'b0 && edge_en === 1'b0 && timeout_err === 1'b0,
              "R1", "outputs in reset", {tck, edge_en, timeout_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tck === 1'b0 && edge_en === 1'b0 && timeout_err === 1'b0,
              "R1", "outputs after reset", {tck, edge_en, timeout_err}, 0);

        // R2/R3: divided-mode sweep
        for (int d = 0; d <= 33; d++) begin
            load_cfg(d, 1'b0);
            run_edges(5, exp_half(d), exp_half(d), 1'b0, 0, (d < 2 || d % 2) ? "R3" : "R2");
        end
        load_cfg(100, 1'b0);
        run_edges(4, 50, 50, 1'b0, 0, "R2");
        load_cfg(8190, 1'b0);
        run_edges(2, 4095, 4095, 1'b0, 0, "R3");
        load_cfg(8191, 1'b0);
        run_edges(2, 4095, 4095, 1'b0, 0, "R3");

        // R5: clock holds while no request
        begin
            logic held = tck;
            bit   moved = 1'b0;
            repeat (30) begin
                @(negedge clk);
                if (tck !== held || edge_en !== 1'b0) moved = 1'b1;
            end
            check(!moved, "R5", "tck held without request", int'(moved), 0);
        end

        // R6: writes while busy are not taken
        load_cfg(10, 1'b0);
        @(negedge clk);
        div_value = DIV_W'(4);
        adaptive_sel = 1'b1;
        run_edges(4, 5, 5, 1'b0, 0, "R6");
        check(timeout_err === 1'b0, "R9", "no error in divided mode", timeout_err, 0);
        @(negedge clk);
        engine_idle = 1'b1;
        adaptive_sel = 1'b0;
        @(negedge clk);
        engine_idle = 1'b0;
        run_edges(4, 2, 2, 1'b0, 0, "R6");

        // R7: adaptive mode with loopback delays
        rclk_in = tck;
        load_cfg(4, 1'b1);
        repeat (4) @(negedge clk);
        run_edges(6, 1, 4, 1'b1, 0, "R7");
        run_edges(6, 1, 7, 1'b1, 3, "R7");
        run_edges(5, 1, 11, 1'b1, 7, "R7");
        check(timeout_err === 1'b0, "R8", "no error with echo", timeout_err, 0);

        // R8: silent target, timeout and continue
        begin
            int e1 = -1, e2 = -1, err_at = -1;
            logic prev;
            rclk_in = tck;
            prev = tck;
            tick_req = 1'b1;
            for (int c = 1; c <= 40 && e2 < 0; c++) begin
                @(negedge clk);
                if (tck !== prev) begin
                    if (e1 < 0) e1 = c; else e2 = c;
                    prev = tck;
                end
                if (timeout_err === 1'b1 && err_at < 0) err_at = c;
            end
            tick_req = 1'b0;
            check(e1 == 1, "R8", "first edge cycle", e1, 1);
            check(err_at == 1 + TMO, "R8", "timeout cycle", err_at, 1 + TMO);
            check(e2 == 2 + TMO, "R8", "edge after timeout", e2, 2 + TMO);
        end

        // R9: sticky until cleared
        repeat (10) @(negedge clk);
        check(timeout_err === 1'b1, "R9", "flag stays set", timeout_err, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(timeout_err === 1'b0, "R9", "flag cleared", timeout_err, 0);

        // R9: back to divided mode without echo never sets the flag
        rclk_in = ~tck;
        load_cfg(6, 1'b0);
        run_edges(6, 3, 3, 1'b0, 0, "R2");
        repeat (TMO + 4) @(negedge clk);
        check(timeout_err === 1'b0, "R9", "divided mode no error", timeout_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule